// File: doc/BRIEF.md
# Edge-Selectable Event Counter Bank

This block counts transitions on a group of asynchronous digital inputs, with one saturating counter for each input. The edge that a channel counts is set at run time, one channel at a time. A channel can count rising transitions or falling transitions, and its neighbours are not affected by that choice. Each input passes through a synchroniser first, and the edge is found on the synchronised level, so a single transition is counted exactly once.

Software-facing logic, or any control engine, works through three narrow ports:
- A polarity write port takes a channel index and the wanted edge.
- A read port takes a channel index and returns that channel's count.
- A clear strobe takes a channel index and zeroes that one counter.

The counters do not wrap. A counter that reaches its maximum value stays there until it is cleared.

Top module: `edge_event_counter_bank`

## Requirements
- R1: After reset every count reads zero, and every channel counts rising edges until its polarity is written.
- R2: A channel set to rising (`pol_fall`=0) adds exactly one for each 0-to-1 transition of its input, and ignores 1-to-0 transitions.
- R3: A channel set to falling (`pol_fall`=1) adds exactly one for each 1-to-0 transition of its input, and ignores 0-to-1 transitions.
- R4: A cycle with `pol_we` high stores `pol_fall` as the edge choice of channel `pol_idx` alone. Each channel then counts its own chosen edge, even when its input switches at the same moment as another channel's input.
- R5: `rd_count` shows, combinationally, the count of the channel selected by `rd_idx`.
- R6: A cycle with `clr_strobe` high makes the count of channel `clr_idx` read zero from the next cycle on. The other channels keep their counts.
- R7: If a clear and a counted edge fall in the same cycle on the same channel, the count is zero afterwards.
- R8: A count that reaches 2^CNT_W-1 holds that value on later edges and does not wrap.
- R9: When a clock edge k first samples a new input level, the count shows the change after clock edge k+SYNC_STAGES, which is k+2 by default. A level that then stays steady adds nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | N_CH | Asynchronous event inputs, one per channel |
| pol_we | input | 1 | Polarity write enable |
| pol_idx | input | IDX_W | Channel whose polarity is written |
| pol_fall | input | 1 | Edge choice: 1 = falling, 0 = rising |
| clr_strobe | input | 1 | Clear one counter |
| clr_idx | input | IDX_W | Channel to clear |
| rd_idx | input | IDX_W | Channel to read |
| rd_count | output | CNT_W | Count of channel `rd_idx` |

## Verification
A wrong polarity bit or a stale edge-history flop shows up at the read port as an off-by-one count. This appears within SYNC_STAGES+1 cycles of the transition that was counted in error, so the bench checks odd and even toggle runs under both polarities. A clear that reaches the wrong channel shows as a changed count on a neighbour channel. A wrap in place of saturation shows as a small value after a long burst. The clear-and-edge collision and the exact latency are checked at the cycle where the count must change.

// File: rtl/eec_pkg.sv
package eec_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/eec_sync.sv
module eec_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/eec_channel.sv
module eec_channel
  import eec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  edge_sel_e        pol,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_q, prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit, sat, cnt_en;

  // edge qualification on the synchronised level
  always_comb begin
    if (pol == EDGE_FALL) hit = prev_q & ~lvl;
    else                  hit = ~prev_q & lvl;
  end

  assign sat    = (cnt_q == CNT_MAX);
  assign cnt_en = clr | (hit & ~sat);

  always_comb begin
    prev_d = lvl;
    cnt_d  = cnt_q;
    if (clr)      cnt_d = '0;
    else if (hit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R6 / R7: a clear always wins
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R8: saturated count holds
  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !clr) |=> (cnt == CNT_MAX));

  // R2 / R3: without clear, a count only stays or steps by one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !sat) |=> ((cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1))));

  // R9: one transition gives one qualified edge
  a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!hit || (pol != $past(pol))));
endmodule

// File: rtl/eec_read_mux.sv
module eec_read_mux #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input  logic [N_CH*CNT_W-1:0] cnt_flat,
  input  logic [IDX_W-1:0]      sel,
  output logic [CNT_W-1:0]      dout
);
  logic [CNT_W-1:0] masked [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_mask
    assign masked[i] = (sel == IDX_W'(i)) ? cnt_flat[i*CNT_W +: CNT_W] : '0;
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < N_CH; i++) dout = dout | masked[i];
  end
endmodule

// File: rtl/edge_event_counter_bank.sv
module edge_event_counter_bank
  import eec_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  din,
  input  logic             pol_we,
  input  logic [IDX_W-1:0] pol_idx,
  input  logic             pol_fall,
  input  logic             clr_strobe,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_count
);
  logic [N_CH-1:0]       din_s;
  logic [N_CH-1:0]       pol_q, pol_d;
  logic [N_CH-1:0]       pol_sel, clr_sel;
  logic [N_CH*CNT_W-1:0] cnt_flat;

  eec_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (din),
    .q_sync  (din_s)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    assign pol_sel[i] = pol_we     && (pol_idx == IDX_W'(i));
    assign clr_sel[i] = clr_strobe && (clr_idx == IDX_W'(i));
  end

  always_comb begin
    pol_d = pol_q;
    for (int i = 0; i < N_CH; i++)
      if (pol_sel[i]) pol_d[i] = pol_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_we) pol_q <= pol_d;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    eec_channel #(.CNT_W(CNT_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (din_s[i]),
      .pol   (edge_sel_e'(pol_q[i])),
      .clr   (clr_sel[i]),
      .cnt   (cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  eec_read_mux #(.N_CH(N_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rd (
    .cnt_flat (cnt_flat),
    .sel      (rd_idx),
    .dout     (rd_count)
  );

  // R4: a polarity write lands on the addressed channel
  a_r4_pol_write: assert property (@(posedge clk) disable iff (!rst_n)
    pol_we |=> (pol_q[$past(pol_idx)] == $past(pol_fall)));

  // R4: channels that are not addressed keep their polarity
  a_r4_pol_other: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_we |=> $stable(pol_q));
endmodule

// File: tb/test_edge_event_counter_bank.sv
module test_edge_event_counter_bank;
  localparam int N_CH  = 8;
  localparam int CNT_W = 8;
  localparam int IDX_W = 3;

  logic             clk;
  logic             rst_n;
  logic [N_CH-1:0]  din;
  logic             pol_we, pol_fall, clr_strobe;
  logic [IDX_W-1:0] pol_idx, clr_idx, rd_idx;
  logic [CNT_W-1:0] rd_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  edge_event_counter_bank #(.N_CH(N_CH), .CNT_W(CNT_W), .SYNC_STAGES(2)) i_edge_event_counter_bank (
    .clk(clk), .rst_n(rst_n), .din(din), .pol_we(pol_we), .pol_idx(pol_idx),
    .pol_fall(pol_fall), .clr_strobe(clr_strobe), .clr_idx(clr_idx),
    .rd_idx(rd_idx), .rd_count(rd_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [2:0] ch;
    logic       fall;
    logic [7:0] toggles;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 1'b0, 8'd1},
    '{3'd1, 1'b0, 8'd6},
    '{3'd2, 1'b1, 8'd1},
    '{3'd3, 1'b1, 8'd7},
    '{3'd4, 1'b0, 8'd9},
    '{3'd5, 1'b1, 8'd10},
    '{3'd6, 1'b1, 8'd2},
    '{3'd7, 1'b0, 8'd13}
  };

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic read_ch(input int ch, output int val);
    @(negedge clk);
    rd_idx = IDX_W'(ch);
    #1;
    val = int'(rd_count);
  endtask

  task automatic set_pol(input int ch, input logic f);
    @(negedge clk);
    pol_we = 1'b1; pol_idx = IDX_W'(ch); pol_fall = f;
    @(negedge clk);
    pol_we = 1'b0;
  endtask

  task automatic clear_ch(input int ch);
    @(negedge clk);
    clr_strobe = 1'b1; clr_idx = IDX_W'(ch);
    @(negedge clk);
    clr_strobe = 1'b0;
  endtask

  task automatic toggle(input logic [N_CH-1:0] mask, input int n, input int gap);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      din = din ^ mask;
      repeat (gap) @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v, nb, exp;
    rst_n = 1'b0; din = '0; pol_we = 0; pol_fall = 0; pol_idx = '0;
    clr_strobe = 0; clr_idx = '0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, every count zero
    for (int c = 0; c < N_CH; c++) begin
      read_ch(c, v);
      check($sformatf("R1 reset count ch%0d", c), v, 0);
    end
    // R1: default polarity is rising -> one rise, one fall gives 1
    toggle(8'h80, 2, 2);
    read_ch(7, v);
    check("R1 default rising polarity", v, 1);

    // R2 R3 R4 R6: vector table
    for (int k = 0; k < 8; k++) begin
      int ch, nbr;
      ch  = int'(VECS[k].ch);
      nbr = (ch + 1) % N_CH;
      @(negedge clk) din[ch] = 1'b0;
      repeat (4) @(posedge clk);
      set_pol(ch, VECS[k].fall);
      clear_ch(ch);
      read_ch(ch, v);
      check($sformatf("R6 cleared ch%0d", ch), v, 0);
      read_ch(nbr, nb);
      toggle(N_CH'(1) << ch, int'(VECS[k].toggles), 2);
      exp = VECS[k].fall ? int'(VECS[k].toggles) / 2 : (int'(VECS[k].toggles) + 1) / 2;
      read_ch(ch, v);
      check($sformatf("%s vec%0d ch%0d count", VECS[k].fall ? "R3" : "R2", k, ch), v, exp);
      read_ch(nbr, v);
      check($sformatf("R4 R5 neighbour ch%0d untouched", nbr), v, nb);
    end

    // R4: simultaneous transitions, different polarities
    din = '0;
    repeat (4) @(posedge clk);
    set_pol(2, 1'b1);
    set_pol(3, 1'b0);
    clear_ch(2);
    clear_ch(3);
    toggle(8'h0C, 3, 2);
    read_ch(2, v);
    check("R4 ch2 falling under shared toggles", v, 1);
    read_ch(3, v);
    check("R4 ch3 rising under shared toggles", v, 2);

    // R9: latency and single count
    @(negedge clk) din = '0;
    repeat (4) @(posedge clk);
    set_pol(0, 1'b0);
    clear_ch(0);
    rd_idx = '0;
    @(negedge clk) din[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); #1;
    check("R9 not yet counted after k+1", int'(rd_count), 0);
    @(posedge clk);
    @(negedge clk); #1;
    check("R9 counted after k+2", int'(rd_count), 1);
    repeat (6) @(posedge clk);
    @(negedge clk); #1;
    check("R9 steady level counted once", int'(rd_count), 1);

    // R7: clear collides with an edge
    @(negedge clk) din[1] = 1'b0;
    repeat (4) @(posedge clk);
    set_pol(1, 1'b0);
    clear_ch(1);
    toggle(8'h02, 6, 2);
    read_ch(1, v);
    check("R7 precondition count", v, 3);
    @(negedge clk) din[1] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) begin clr_strobe = 1'b1; clr_idx = 3'd1; end
    @(negedge clk) clr_strobe = 1'b0;
    read_ch(1, v);
    check("R7 clear beats edge", v, 0);
    repeat (4) @(posedge clk);
    read_ch(1, v);
    check("R7 stays zero", v, 0);

    // R8: saturation
    @(negedge clk) din[5] = 1'b0;
    repeat (4) @(posedge clk);
    set_pol(5, 1'b0);
    clear_ch(5);
    toggle(8'h20, 600, 1);
    read_ch(5, v);
    check("R8 saturates at max", v, (1 << CNT_W) - 1);
    toggle(8'h20, 4, 2);
    read_ch(5, v);
    check("R8 holds at max", v, (1 << CNT_W) - 1);
    clear_ch(5);
    read_ch(5, v);
    check("R6 clear after saturation", v, 0);

    finish_run();
  end
endmodule